// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell sitting behind one sum-of-products term of a programmable logic array. It takes the OR sum and can either pass it straight to the pin or capture it in a D flip-flop. It can then invert it, and it drives the pin only while the output-enable product term is true. It also returns one of three signals to the array as feedback: the pin value, the flip-flop output or the raw OR sum. The choice of feedback does not depend on whether the output is registered.

The flip-flop captures on a rising edge of a selected clock. A small selector picks that clock from either the clock pin or a clock product term, in true or complement form. Everything runs on one system clock. A rising edge of the selected clock becomes a one-cycle capture enable, and the capture happens at the next system clock edge. A global preset term sets the flip-flop at a capture. A global clear term forces it to zero at once and takes priority over preset. Four configuration bits give twelve valid configurations. The one left-over feedback code behaves as pin feedback.

Top module: `macro_cell`

## Requirements
- R1: `cfg[0]` sets polarity. With 1 the pin shows the selected data unchanged; with 0 it shows the inverse.
- R2: `cfg[1]` sets the output type. With 0 the pin data is `or_sum` in the same cycle, with no clock needed; with 1 it is the flip-flop output.
- R3: The flip-flop loads `or_sum` at the first system clock edge after the selected clock rises from 0 to 1. It holds its value while the selected clock stays high, on its falling edge, and while it stays low.
- R4: If `preset_term` is 1 at a capture edge and `clear_term` is 0, the flip-flop becomes 1 whatever `or_sum` is.
- R5: While `clear_term` is 1, the flip-flop output reads 0 in that same cycle without any clock. After clear is released, it keeps reading 0 until the next capture.
- R6: If `preset_term` and `clear_term` are both 1 at a capture edge, the flip-flop ends at 0.
- R7: `cfg[3:2]` picks the feedback. 00 gives `pin_in`, 01 gives the flip-flop output, 10 gives `or_sum`, and the reserved code 11 gives `pin_in`.
- R8: `pin_oe` equals `oe_term`. While `oe_term` is 0, `pin_out` is 0 for every configuration, and the feedback is unaffected.
- R9: The selected clock is `clk_pterm` when `clk_src_sel` is 1 and `clk_pin` when it is 0, inverted when `clk_invert` is 1. With inversion on, a falling edge of the source is the capture edge. The source that is not selected causes no capture.
- R10: Reset clears the flip-flop to 0. A selected clock that is already high when reset is released does not cause a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| or_sum | input | 1 | OR sum from the array |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| clk_pin | input | 1 | Clock pin level |
| clk_pterm | input | 1 | Clock product term level |
| clk_src_sel | input | 1 | 1 selects the product-term clock |
| clk_invert | input | 1 | 1 selects the complement clock |
| pin_in | input | 1 | Value seen at the pin |
| cfg | input | 4 | Cell configuration bits |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback to the array |

## Verification
The combinational results are due in the same cycle as the stimulus. These are polarity, the combinational output, feedback selection, the enable, and the immediate effect of clear. The bench drives them just after a falling system clock edge and samples them 1 ns later, before the next rising edge.

A selected-clock rise driven after a falling edge gives a capture enable that is taken at the following rising edge. The registered result is therefore sampled at the next falling edge. Reset release passes through the synchronizer, and the bench waits past it before its first check. Each check pushes its expected item into the scoreboard queue at the moment its result is due.

// File: rtl/macro_cell_pkg.sv
package macro_cell_pkg;

  localparam int CFG_W = 4;

  typedef enum logic [1:0] {
    FB_PIN  = 2'b00,
    FB_REG  = 2'b01,
    FB_SUM  = 2'b10,
    FB_RSVD = 2'b11
  } fb_sel_e;

  typedef struct packed {
    fb_sel_e fb;
    logic    registered;
    logic    active_high;
  } cell_cfg_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mc_clk_sel.sv
module mc_clk_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic src_pin,
  input  logic src_pterm,
  input  logic use_pterm,
  input  logic invert,
  output logic cap_en
);

  logic sel_lvl;
  logic lvl_q;
  logic lvl_nxt;

  always_comb begin
    sel_lvl = (use_pterm ? src_pterm : src_pin) ^ invert;
    lvl_nxt = sel_lvl;
  end

  // Reset value 1: a clock already high at release is not an edge (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_nxt;
  end

  assign cap_en = sel_lvl & ~lvl_q;

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> !cap_en);

  p_needs_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_lvl |=> !cap_en || $rose(sel_lvl));

endmodule

// File: rtl/mc_dff.sv
module mc_dff (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic d_i,
  input  logic preset_i,
  input  logic clear_i,
  output logic q_o
);

  logic q_reg;
  logic q_nxt;
  logic q_en;

  always_comb begin
    q_en = cap_en | clear_i;
    if (clear_i)       q_nxt = 1'b0;
    else if (preset_i) q_nxt = 1'b1;
    else               q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_reg <= 1'b0;
    else if (q_en) q_reg <= q_nxt;
  end

  assign q_o = q_reg & ~clear_i;

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !preset_i && !clear_i) |=> (q_reg == $past(d_i)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !clear_i) |=> $stable(q_reg));

  p_preset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && preset_i && !clear_i) |=> q_reg);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !q_reg);

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && preset_i && clear_i) |=> !q_reg);

endmodule

// File: rtl/mc_out_path.sv
module mc_out_path
  import macro_cell_pkg::*;
(
  input  cell_cfg_t cfg_i,
  input  logic      sum_i,
  input  logic      q_i,
  input  logic      oe_i,
  input  logic      pin_i,
  output logic      pin_o,
  output logic      pin_oe_o,
  output logic      fb_o
);

  logic data_sel;
  logic data_pol;

  always_comb begin
    data_sel = cfg_i.registered ? q_i : sum_i;
    data_pol = cfg_i.active_high ? data_sel : ~data_sel;
    pin_o    = oe_i ? data_pol : 1'b0;
    pin_oe_o = oe_i;
    unique case (cfg_i.fb)
      FB_REG:  fb_o = q_i;
      FB_SUM:  fb_o = sum_i;
      default: fb_o = pin_i;
    endcase
  end

  always_comb begin
    if (oe_i && cfg_i.registered && cfg_i.active_high)
      a_reg_high_r2: assert (pin_o == q_i);
  end

endmodule

// File: rtl/macro_cell.sv
module macro_cell
  import macro_cell_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             or_sum,
  input  logic             oe_term,
  input  logic             preset_term,
  input  logic             clear_term,
  input  logic             clk_pin,
  input  logic             clk_pterm,
  input  logic             clk_src_sel,
  input  logic             clk_invert,
  input  logic             pin_in,
  input  logic [CFG_W-1:0] cfg,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);

  cell_cfg_t cfg_s;
  logic      rst_sync_n;
  logic      cap_en;
  logic      q_eff;

  assign cfg_s = cell_cfg_t'(cfg);

  mc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mc_clk_sel u_clk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_pin   (clk_pin),
    .src_pterm (clk_pterm),
    .use_pterm (clk_src_sel),
    .invert    (clk_invert),
    .cap_en    (cap_en)
  );

  mc_dff u_ff (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_en   (cap_en),
    .d_i      (or_sum),
    .preset_i (preset_term),
    .clear_i  (clear_term),
    .q_o      (q_eff)
  );

  mc_out_path u_out (
    .cfg_i    (cfg_s),
    .sum_i    (or_sum),
    .q_i      (q_eff),
    .oe_i     (oe_term),
    .pin_i    (pin_in),
    .pin_o    (pin_out),
    .pin_oe_o (pin_oe),
    .fb_o     (fb_out)
  );

  p_rsvd_pin_fb_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_s.fb == FB_RSVD) |-> (fb_out == pin_in));

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !oe_term |-> (!pin_oe && !pin_out));

  p_clear_output_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clear_term && cfg_s.registered && cfg_s.active_high && oe_term) |-> !pin_out);

endmodule

// File: tb/macro_cell_tb_top.sv
module macro_cell_tb_top;

  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic  out;
    logic  oe;
    logic  fb;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       or_sum, oe_term, preset_term, clear_term;
  logic       clk_pin, clk_pterm, clk_src_sel, clk_invert, pin_in;
  logic [3:0] cfg;
  logic       pin_out, pin_oe, fb_out;

  int   checks   = 0;
  int   failures = 0;
  bit   done     = 1'b0;
  exp_t sb[$];
  event chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  macro_cell dut_i (
    .clk(clk), .rst_n(rst_n), .or_sum(or_sum), .oe_term(oe_term),
    .preset_term(preset_term), .clear_term(clear_term),
    .clk_pin(clk_pin), .clk_pterm(clk_pterm), .clk_src_sel(clk_src_sel),
    .clk_invert(clk_invert), .pin_in(pin_in), .cfg(cfg),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_now(input logic o, input logic e, input logic f, input string tag);
    exp_t it;
    #1;
    it.out = o; it.oe = e; it.fb = f; it.tag = tag;
    sb.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic pulse_pin();
    clk_pin = 1'b1; tick();
    clk_pin = 1'b0; tick();
  endtask

  task automatic pulse_pterm();
    clk_pterm = 1'b1; tick();
    clk_pterm = 1'b0; tick();
  endtask

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (pin_out !== it.out || pin_oe !== it.oe || fb_out !== it.fb) begin
          failures++;
          $display("FAIL %s: got out=%b oe=%b fb=%b expected out=%b oe=%b fb=%b",
                   it.tag, pin_out, pin_oe, fb_out, it.out, it.oe, it.fb);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; or_sum = 1'b1; oe_term = 1'b1; preset_term = 1'b0;
    clear_term = 1'b0; clk_pin = 1'b1; clk_pterm = 1'b0; clk_src_sel = 1'b0;
    clk_invert = 1'b0; pin_in = 1'b0; cfg = 4'b0111;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    expect_now(0, 1, 0, "R10 reset clear, no capture from clock high at release");

    clk_pin = 1'b0; tick(); clk_pin = 1'b1; tick();
    expect_now(1, 1, 1, "R3 capture on selected clock rise");
    or_sum = 1'b0; tick();
    expect_now(1, 1, 1, "R3 hold while clock stays high");
    clk_pin = 1'b0; tick();
    expect_now(1, 1, 1, "R3 hold on clock fall");

    cfg = 4'b0110;
    expect_now(0, 1, 1, "R1 registered active-low");
    cfg = 4'b0101;
    expect_now(0, 1, 1, "R2 combinational follows sum 0");
    or_sum = 1'b1;
    expect_now(1, 1, 1, "R2 combinational follows sum 1 without clock");
    cfg = 4'b0100;
    expect_now(0, 1, 1, "R1 combinational active-low");

    cfg = 4'b0111; or_sum = 1'b0; pulse_pin();
    expect_now(0, 1, 0, "R3 capture of 0");
    preset_term = 1'b1; pulse_pin(); preset_term = 1'b0;
    expect_now(1, 1, 1, "R4 preset sets register over sum 0");

    clear_term = 1'b1;
    expect_now(0, 1, 0, "R5 clear acts in same cycle");
    tick(); clear_term = 1'b0;
    expect_now(0, 1, 0, "R5 register stays cleared after release");

    preset_term = 1'b1; pulse_pin();
    expect_now(1, 1, 1, "R4 preset again");
    clear_term = 1'b1; pulse_pin(); clear_term = 1'b0; preset_term = 1'b0;
    expect_now(0, 1, 0, "R6 clear beats preset");

    preset_term = 1'b1; pulse_pin(); preset_term = 1'b0;
    or_sum = 1'b0; pin_in = 1'b0; cfg = 4'b1011;
    expect_now(1, 1, 0, "R7 sum feedback 0 with registered output 1");
    or_sum = 1'b1;
    expect_now(1, 1, 1, "R7 sum feedback 1");
    cfg = 4'b0011;
    expect_now(1, 1, 0, "R7 pin feedback 0");
    pin_in = 1'b1;
    expect_now(1, 1, 1, "R7 pin feedback 1");
    pin_in = 1'b0; cfg = 4'b1111;
    expect_now(1, 1, 0, "R7 reserved code gives pin feedback");
    cfg = 4'b0111;
    expect_now(1, 1, 1, "R7 register feedback");

    oe_term = 1'b0;
    expect_now(0, 0, 1, "R8 disabled pin, feedback kept");
    cfg = 4'b0110;
    expect_now(0, 0, 1, "R8 disabled pin active-low");
    cfg = 4'b0111; oe_term = 1'b1;

    or_sum = 1'b0; clk_src_sel = 1'b1; tick();
    pulse_pin();
    expect_now(1, 1, 1, "R9 unselected pin clock ignored");
    pulse_pterm();
    expect_now(0, 1, 0, "R9 product-term clock captures");
    clk_invert = 1'b1; tick();
    or_sum = 1'b1; clk_pterm = 1'b1; tick(); tick();
    expect_now(0, 1, 0, "R9 inverted clock ignores source rise");
    clk_pterm = 1'b0; tick();
    expect_now(1, 1, 1, "R9 inverted clock captures on source fall");

    tick();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule